// File: doc/BRIEF.md
# Single-Accumulator Processor with Device Port

This block is a small processor with one accumulator. It runs a program held in its own word memory. It has three architectural registers: a program counter, an instruction register and an accumulator. Every instruction is one 16-bit word. The top four bits select the operation. The low twelve bits name either a memory word or an I/O device, and the operation decides which. Memory operations load, store and add. Device operations read a word from the device port into the accumulator, or write the accumulator out to a numbered device.

The memory sits inside the block and has no external access path. A testbench fills it with a program and data while reset is held. After reset is released, the core fetches from word 0 and keeps running until it reaches a halt instruction. A controller with three states sequences the work. The states are FETCH, EXEC and HALT. Transition T_FETCH goes from FETCH to EXEC and loads the instruction register. Transition T_NEXT goes from EXEC back to FETCH. Transition T_STOP goes from EXEC to HALT when the instruction is a halt. Transition T_PARK keeps the controller in HALT until reset.

Top module: `accum_core`

## Requirements
- R1: Each instruction word carries the operation in bits 15..12 and the address/device field in bits 11..0. It takes one FETCH cycle and then one EXEC cycle. FETCH loads the instruction register and increments the program counter by one. The first fetch is from word 0.
- R2: Operation 0001 copies the addressed memory word into the accumulator.
- R3: Operation 0101 adds the addressed memory word to the accumulator. The sum wraps modulo 2^16, and the sign bit 15 takes the carry into it.
- R4: Operation 0010 writes the accumulator into the addressed memory word.
- R5: Operation 0011 loads io_rdata into the accumulator. During that EXEC cycle, io_rd is high for exactly one clock and io_dev carries the 12-bit field.
- R6: Operation 0111 raises io_wr for exactly one clock. During that clock, io_dev carries the field and io_wdata carries the accumulator.
- R7: Operation 0000 moves the controller to HALT. While in HALT, done stays high, and no further instruction runs and no I/O strobe occurs until reset.
- R8: All other operation codes change neither the accumulator nor the memory. They set the illegal output, which stays high until reset.
- R9: While reset is low, done, illegal, io_wr and io_rd are 0.
- R10: Memory is indexed by the low MEM_AW bits of the field (8 by default), so a field of 0x340 addresses word 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_rdata | input | 16 | Data returned by the addressed device for device loads |
| io_wr | output | 1 | One-clock device write strobe |
| io_rd | output | 1 | One-clock device read strobe |
| io_dev | output | 12 | Device number from the instruction field |
| io_wdata | output | 16 | Accumulator value written to the device |
| done | output | 1 | High once a halt has executed |
| illegal | output | 1 | Sticky flag for an unlisted operation code |

## Verification
Several properties are checked on every cycle. Both device strobes must be single-clock pulses. Done and illegal must stay high once set. No strobe may occur after a halt. FETCH must always be followed by EXEC and must advance the program counter by one. An unlisted operation must leave the accumulator unchanged. The arithmetic results, the two-cycle timing and the field truncation used for memory indexing can only be shown by the bench's programs. Those programs include sums that overflow into the sign bit and wrap to zero, a device round trip, an illegal code and an early halt.

// File: rtl/accp_pkg.sv
package accp_pkg;

    localparam logic [3:0] OPC_HALT  = 4'b0000;
    localparam logic [3:0] OPC_LDMEM = 4'b0001;
    localparam logic [3:0] OPC_STMEM = 4'b0010;
    localparam logic [3:0] OPC_LDDEV = 4'b0011;
    localparam logic [3:0] OPC_ADMEM = 4'b0101;
    localparam logic [3:0] OPC_STDEV = 4'b0111;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } state_e;

    typedef struct packed {
        logic ld_mem;
        logic add_mem;
        logic st_mem;
        logic ld_dev;
        logic st_dev;
        logic halt;
        logic bad;
    } ctrl_t;

endpackage

// File: rtl/accp_mem.sv
module accp_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/accp_decode.sv
module accp_decode
    import accp_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OPC_HALT:  ctrl.halt    = 1'b1;
            OPC_LDMEM: ctrl.ld_mem  = 1'b1;
            OPC_STMEM: ctrl.st_mem  = 1'b1;
            OPC_LDDEV: ctrl.ld_dev  = 1'b1;
            OPC_ADMEM: ctrl.add_mem = 1'b1;
            OPC_STDEV: ctrl.st_dev  = 1'b1;
            default:   ctrl.bad     = 1'b1;
        endcase
    end

    always_comb begin
        assert_decode_onehot_R8: assert ($onehot0(ctrl))
            else $error("decoder produced more than one control");
    end

endmodule

// File: rtl/accp_ctrl.sv
module accp_ctrl
    import accp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    output logic fetch_en,
    output logic exec_en,
    output logic done
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;                          // T_FETCH
            ST_EXEC:  state_d = halt_req ? ST_HALT : ST_FETCH;    // T_STOP / T_NEXT
            ST_HALT:  state_d = ST_HALT;                          // T_PARK
            default:  state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fetch_en = 1'b0;
        exec_en  = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_FETCH: fetch_en = rst_n;
            ST_EXEC:  exec_en  = rst_n;
            ST_HALT:  done     = rst_n;
            default:  ;
        endcase
    end

    assert_fetch_then_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> exec_en)
        else $error("FETCH not followed by EXEC");

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done)
        else $error("done dropped without reset");

    assert_halt_no_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!fetch_en && !exec_en))
        else $error("work after halt");

endmodule

// File: rtl/accum_core.sv
module accum_core
    import accp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int OP_W   = 4,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              io_wr,
    output logic              io_rd,
    output logic [ADDR_W-1:0] io_dev,
    output logic [DATA_W-1:0] io_wdata,
    output logic              done,
    output logic              illegal
);
    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int OP_LSB  = ADDR_W;

    logic [ADDR_W-1:0]  pc_q;
    logic [INSTR_W-1:0] ir_q;
    logic [DATA_W-1:0]  acc_q;
    logic               bad_q;

    logic               fetch_en, exec_en;
    ctrl_t              ctrl;
    logic [MEM_AW-1:0]  mem_addr;
    logic [DATA_W-1:0]  mem_rdata;
    logic               mem_we;
    logic [ADDR_W-1:0]  field;

    assign field = ir_q[ADDR_W-1:0];

    accp_decode #(.OP_W(OP_W)) u_dec (
        .opcode (ir_q[INSTR_W-1:OP_LSB]),
        .ctrl   (ctrl)
    );

    accp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (ctrl.halt),
        .fetch_en (fetch_en),
        .exec_en  (exec_en),
        .done     (done)
    );

    assign mem_addr = fetch_en ? pc_q[MEM_AW-1:0] : field[MEM_AW-1:0];
    assign mem_we   = exec_en && ctrl.st_mem;

    accp_mem #(.DW(DATA_W), .AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (acc_q),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            bad_q <= 1'b0;
        end else begin
            if (fetch_en) begin
                ir_q <= mem_rdata[INSTR_W-1:0];
                pc_q <= pc_q + 1'b1;
            end
            if (exec_en) begin
                if (ctrl.ld_mem)  acc_q <= mem_rdata;
                if (ctrl.add_mem) acc_q <= acc_q + mem_rdata;
                if (ctrl.ld_dev)  acc_q <= io_rdata;
                if (ctrl.bad)     bad_q <= 1'b1;
            end
        end
    end

    assign io_wr    = exec_en && ctrl.st_dev;
    assign io_rd    = exec_en && ctrl.ld_dev;
    assign io_dev   = field;
    assign io_wdata = acc_q;
    assign illegal  = bad_q;

    assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> !io_wr)
        else $error("io_wr longer than one clock");

    assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !io_rd)
        else $error("io_rd longer than one clock");

    assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> (pc_q == $past(pc_q) + 1'b1))
        else $error("pc did not advance by one");

    assert_illegal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal)
        else $error("illegal flag dropped");

    assert_bad_keeps_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && ctrl.bad) |=> $stable(acc_q))
        else $error("unlisted opcode changed accumulator");

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!io_wr && !io_rd))
        else $error("strobe after halt");

endmodule

// File: tb/accum_core_tb.sv
module accum_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_rdata = 16'h0000;
    logic        io_wr, io_rd, done, illegal;
    logic [11:0] io_dev;
    logic [15:0] io_wdata;

    int checks = 0;
    int failures = 0;
    int wr_n = 0;
    int rd_n = 0;
    logic [11:0] wr_dev [4];
    logic [15:0] wr_dat [4];
    logic [11:0] rd_dev;
    int cyc;

    always #2 clk = ~clk;

    accum_core u_dut (
        .clk(clk), .rst_n(rst_n), .io_rdata(io_rdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_dev(io_dev),
        .io_wdata(io_wdata), .done(done), .illegal(illegal)
    );

    always @(negedge clk) begin
        if (rst_n && io_wr) begin
            if (wr_n < 4) begin
                wr_dev[wr_n] = io_dev;
                wr_dat[wr_n] = io_wdata;
            end
            wr_n = wr_n + 1;
        end
        if (rst_n && io_rd) begin
            rd_dev = io_dev;
            rd_n = rd_n + 1;
        end
    end

    // each entry: operand A, operand B, expected 16-bit sum
    localparam logic [47:0] VEC [4] = '{
        {16'h0003, 16'h0002, 16'h0005},
        {16'h7FFF, 16'h0001, 16'h8000},
        {16'hFFFF, 16'h0001, 16'h0000},
        {16'h1234, 16'hEDCB, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [15:0] v);
        u_dut.u_mem.mem[a] = v;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 256; i++) poke(i, 16'h0000);
        wr_n = 0;
        rd_n = 0;
    endtask

    task automatic run(input int limit);
        rst_n = 1'b1;
        cyc = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            cyc++;
            if (done) break;
        end
        if (!done) chk("R7 watchdog done", 0, 1);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog run expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        hold_reset();
        // R9: outputs quiet while reset is low
        chk("R9 done", done, 0);
        chk("R9 illegal", illegal, 0);
        chk("R9 io_wr", io_wr, 0);
        chk("R9 io_rd", io_rd, 0);

        for (int v = 0; v < 4; v++) begin
            hold_reset();
            poke(0, 16'h1040); poke(1, 16'h5041); poke(2, 16'h2042);
            poke(3, 16'h1040); poke(4, 16'h7120); poke(5, 16'h1042);
            poke(6, 16'h7123); poke(7, 16'h0000);
            poke(8'h40, VEC[v][47:32]);
            poke(8'h41, VEC[v][31:16]);
            run(100);
            chk("R1 cycles to halt", cyc, 16);
            chk("R6 write count", wr_n, 2);
            chk("R2 loaded value", wr_dat[0], VEC[v][47:32]);
            chk("R6 device", wr_dev[0], 12'h120);
            chk("R3 R4 stored sum", wr_dat[1], VEC[v][15:0]);
            chk("R6 device 2", wr_dev[1], 12'h123);
            chk("R8 no illegal", illegal, 0);
        end

        // R5: device round trip
        hold_reset();
        io_rdata = 16'hBEEF;
        poke(0, 16'h3055); poke(1, 16'h70AB); poke(2, 16'h0000);
        run(50);
        chk("R5 read count", rd_n, 1);
        chk("R5 read device", rd_dev, 12'h055);
        chk("R5 loaded data", wr_dat[0], 16'hBEEF);
        chk("R6 write device", wr_dev[0], 12'h0AB);

        // R8: unlisted codes are no-ops and set the sticky flag
        hold_reset();
        poke(0, 16'h1040); poke(1, 16'h4040); poke(2, 16'hF041);
        poke(3, 16'h7001); poke(4, 16'h0000);
        poke(8'h40, 16'h1111); poke(8'h41, 16'h2222);
        run(50);
        chk("R8 illegal set", illegal, 1);
        chk("R8 acc unchanged", wr_dat[0], 16'h1111);
        chk("R8 cycles", cyc, 10);

        // R9: reset clears illegal and done
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 illegal cleared", illegal, 0);
        chk("R9 done cleared", done, 0);

        // R7: early halt, nothing after it
        hold_reset();
        poke(0, 16'h0000); poke(1, 16'h7001); poke(2, 16'h7002);
        run(50);
        chk("R7 halt cycles", cyc, 2);
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk("R7 no writes after halt", wr_n, 0);
        chk("R7 done held", done, 1);

        // R10: field truncated to the memory index width
        hold_reset();
        poke(0, 16'h1340); poke(1, 16'h7010); poke(2, 16'h0000);
        poke(8'h40, 16'h5A5A);
        run(50);
        chk("R10 aliased load", wr_dat[0], 16'h5A5A);
        chk("R10 device", wr_dev[0], 12'h010);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule